// File: doc/BRIEF.md
# Triangle Spread-Spectrum Divider Modulator

This block drives the divide ratio of a fractional-N feedback divider so that the synthesized clock sweeps down and back in a triangle. The ratio is 24 bits wide: the top 8 bits are the integer part and the low 16 bits are the fraction. The programmed nominal ratio P is the crest of the triangle. On each tick (one strobe per divided output cycle) the ratio falls by a 16-bit step. After a number of ticks set by a 12-bit period value, it climbs back by the same step. The generator only ever spreads downward. A centred spread is obtained by supplying an already raised P.

When spreading is off, the output is P and nothing else matters. A rising edge of the enable restarts the sweep from the crest, heading down, with the ramp counter cleared. Decoding of the configuration registers and the sigma-delta stage that consumes the ratio sit outside this block.

Top module: `ssc_tri_mod`

## Requirements
- R1: While `ss_en` is 0, `div_val` equals `nom_p` in the same cycle, whatever `tick`, `period` and `step` do.
- R2: The cycle after `ss_en` rises, `div_val` equals the `nom_p` of the rising cycle; the next ramp that follows heads downward with its tick count cleared.
- R3: Each tick on a downward ramp lowers `div_val` by `step`, with `step` added to the low end of the 24-bit value (bits 15:0 are fraction, bits 23:16 integer); each tick on an upward ramp raises it by `step`.
- R4: A cycle without a tick leaves `div_val` unchanged while it is not above `nom_p`.
- R5: Each ramp lasts exactly 2×`period` ticks, after which the direction reverses; the final tick of an upward ramp lands exactly on `nom_p`.
- R6: A downward step larger than the remaining value saturates the result at zero instead of wrapping.
- R7: With spreading active, `div_val` never exceeds `nom_p`; an upward step that would overshoot stops at `nom_p`, and lowering `nom_p` pulls the output down to it on the next cycle.
- R8: A `period` of 0 holds the output at `nom_p` regardless of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One strobe per divided output cycle |
| ss_en | input | 1 | Spread enable |
| nom_p | input | 24 | Nominal ratio P, crest of the triangle (8.16 fixed point) |
| period | input | 12 | Half the number of ticks in one ramp |
| step | input | 16 | Per-tick ratio change, in fraction LSBs |
| div_val | output | 24 | Current divide ratio (8.16 fixed point) |

## Verification
The bench walks a full down-and-up triangle and then the first tick past the turn. An off-by-one in the ramp counter would shift the turning point, and a missing direction flip would keep the ratio sinking. It drives a step larger than the remaining value to catch a subtractor that wraps to a huge ratio, and it lets the upward ramp overshoot to catch a missing crest clamp. It drops and re-raises the enable mid-ramp, where stale counter or direction state would make the restarted sweep turn early or climb. It also lowers P under a running sweep and uses a zero period, where a design without a clamp or a guard would sit above the new crest or drift on every tick.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    parameter int SSC_INT_W  = 8;
    parameter int SSC_FRAC_W = 16;
    parameter int SSC_PER_W  = 12;
    parameter int SSC_STEP_W = 16;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } ssc_dir_e;

endpackage

// File: rtl/ssc_ramp_ctrl.sv
// Ramp timer: counts ticks within a ramp and reverses direction at its end.
module ssc_ramp_ctrl
    import ssc_pkg::*;
#(
    parameter int PER_W = SSC_PER_W
) (
    input  logic               advance,
    input  logic [PER_W-1:0]   period,
    input  logic [PER_W:0]     cnt_q,
    input  ssc_dir_e           dir_q,
    output logic [PER_W:0]     cnt_d,
    output ssc_dir_e           dir_d,
    output logic               ramp_end
);

    localparam int CNT_W = PER_W + 1;

    logic [CNT_W-1:0] last_idx;

    // A ramp spans twice the period value in ticks.
    assign last_idx = {period, 1'b0} - CNT_W'(1);

    always_comb begin
        cnt_d    = cnt_q;
        dir_d    = dir_q;
        ramp_end = advance && (cnt_q >= last_idx);
        if (ramp_end) begin
            cnt_d = '0;
            dir_d = (dir_q == DIR_DOWN) ? DIR_UP : DIR_DOWN;
        end else if (advance) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ssc_val_step.sv
// Next-value arithmetic: saturating step down, clamped step up, crest limit.
module ssc_val_step
    import ssc_pkg::*;
#(
    parameter int VAL_W  = SSC_INT_W + SSC_FRAC_W,
    parameter int STEP_W = SSC_STEP_W
) (
    input  logic               advance,
    input  logic               reload,
    input  ssc_dir_e           dir,
    input  logic [VAL_W-1:0]   val_q,
    input  logic [STEP_W-1:0]  step,
    input  logic [VAL_W-1:0]   peak,
    output logic [VAL_W-1:0]   val_d
);

    localparam int EXT_W = VAL_W + 1;

    logic [EXT_W-1:0] dn_ext;
    logic [EXT_W-1:0] up_ext;
    logic [VAL_W-1:0] cand;

    assign dn_ext = {1'b0, val_q} - EXT_W'(step);
    assign up_ext = {1'b0, val_q} + EXT_W'(step);

    always_comb begin
        cand = val_q;
        if (advance) begin
            if (reload) begin
                cand = peak;
            end else if (dir == DIR_DOWN) begin
                cand = dn_ext[VAL_W] ? '0 : dn_ext[VAL_W-1:0];
            end else begin
                cand = (up_ext > {1'b0, peak}) ? peak : up_ext[VAL_W-1:0];
            end
        end
        // The crest bounds the value every cycle, tick or not.
        val_d = (cand > peak) ? peak : cand;
    end

endmodule

// File: rtl/ssc_tri_mod.sv
module ssc_tri_mod
    import ssc_pkg::*;
#(
    parameter int INT_W  = SSC_INT_W,
    parameter int FRAC_W = SSC_FRAC_W,
    parameter int PER_W  = SSC_PER_W,
    parameter int STEP_W = SSC_STEP_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      ss_en,
    input  logic [INT_W+FRAC_W-1:0]   nom_p,
    input  logic [PER_W-1:0]          period,
    input  logic [STEP_W-1:0]         step,
    output logic [INT_W+FRAC_W-1:0]   div_val
);

    localparam int VAL_W = INT_W + FRAC_W;
    localparam int CNT_W = PER_W + 1;

    typedef struct packed {
        logic             en;
        ssc_dir_e         dir;
        logic [CNT_W-1:0] cnt;
        logic [VAL_W-1:0] val;
    } state_t;

    state_t s_d, s_q;

    logic             advance;
    logic             ramp_end;
    logic [CNT_W-1:0] cnt_nx;
    ssc_dir_e         dir_nx;
    logic [VAL_W-1:0] val_nx;

    assign advance = tick && ss_en && s_q.en && (period != '0);

    ssc_ramp_ctrl #(
        .PER_W (PER_W)
    ) u_ramp (
        .advance  (advance),
        .period   (period),
        .cnt_q    (s_q.cnt),
        .dir_q    (s_q.dir),
        .cnt_d    (cnt_nx),
        .dir_d    (dir_nx),
        .ramp_end (ramp_end)
    );

    ssc_val_step #(
        .VAL_W  (VAL_W),
        .STEP_W (STEP_W)
    ) u_step (
        .advance (advance),
        .reload  (ramp_end && (s_q.dir == DIR_UP)),
        .dir     (s_q.dir),
        .val_q   (s_q.val),
        .step    (step),
        .peak    (nom_p),
        .val_d   (val_nx)
    );

    always_comb begin
        s_d    = s_q;
        s_d.en = ss_en;
        if (ss_en && !s_q.en) begin
            s_d.dir = DIR_DOWN;
            s_d.cnt = '0;
            s_d.val = nom_p;
        end else if (ss_en) begin
            s_d.dir = dir_nx;
            s_d.cnt = cnt_nx;
            s_d.val = val_nx;
        end else begin
            s_d.dir = DIR_DOWN;
            s_d.cnt = '0;
            s_d.val = nom_p;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.en  <= 1'b0;
            s_q.dir <= DIR_DOWN;
            s_q.cnt <= '0;
            s_q.val <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign div_val = (ss_en && s_q.en) ? s_q.val : nom_p;

endmodule

// File: rtl/ssc_tri_mod_chk.sv
module ssc_tri_mod_chk #(
    parameter int VAL_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ss_en,
    input logic [VAL_W-1:0] nom_p,
    input logic [VAL_W-1:0] div_val
);

    a_r1_bypass_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ss_en |-> div_val == nom_p);

    a_r2_restart_at_crest: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ss_en) |=> (!ss_en || div_val == $past(nom_p)));

    a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_en && !tick && div_val <= nom_p) |=> (!ss_en || $stable(div_val)));

    a_r7_below_crest: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_en && $past(ss_en) && $stable(nom_p)) |-> div_val <= nom_p);

endmodule

bind ssc_tri_mod ssc_tri_mod_chk #(.VAL_W(INT_W + FRAC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .ss_en   (ss_en),
    .nom_p   (nom_p),
    .div_val (div_val)
);

// File: tb/ssc_tri_mod_tb.sv
`timescale 1ns/1ps
module ssc_tri_mod_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ss_en = 1'b0;
    logic [23:0] nom_p = 24'h12_3456;
    logic [11:0] period = 12'd3;
    logic [15:0] step = 16'h0400;
    logic [23:0] div_val;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    ssc_tri_mod u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .ss_en   (ss_en),
        .nom_p   (nom_p),
        .period  (period),
        .step    (step),
        .div_val (div_val)
    );

    task automatic chk(input string req, input logic [23:0] exp);
        checks++;
        if (div_val !== exp) begin
            errors++;
            $display("FAIL %s: div_val=%h expected=%h", req, div_val, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the tick applied.
    task automatic pulse();
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic restart(input logic [23:0] p, input logic [11:0] per, input logic [15:0] st);
        ss_en  = 1'b0;
        nom_p  = p;
        period = per;
        step   = st;
        @(negedge clk);
        ss_en = 1'b1;
        @(negedge clk);
        chk("R2 crest after enable", p);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 reset bypass", 24'h12_3456);
    endtask

    task automatic t_disabled();
        ss_en  = 1'b0;
        nom_p  = 24'h0A_8000;
        period = 12'd1;
        step   = 16'hFFFF;
        for (int i = 0; i < 4; i++) begin
            pulse();
            chk("R1 ticks ignored while off", 24'h0A_8000);
        end
        nom_p = 24'h0B_0001;
        #1;
        chk("R1 same-cycle follow of P", 24'h0B_0001);
        @(negedge clk);
    endtask

    task automatic t_triangle();
        restart(24'h12_3456, 12'd3, 16'h0400);
        for (int k = 1; k <= 6; k++) begin
            pulse();
            chk("R3 down step", 24'h12_3456 - 24'(k) * 24'h400);
            if (k == 3) begin
                repeat (5) @(negedge clk);
                chk("R4 hold without tick", 24'h12_3456 - 24'hC00);
            end
        end
        for (int k = 1; k <= 6; k++) begin
            pulse();
            chk("R5 up ramp after 2*period", 24'h12_3456 - 24'(6 - k) * 24'h400);
        end
        pulse();
        chk("R5 turns down at crest", 24'h12_3456 - 24'h400);
    endtask

    task automatic t_saturate();
        restart(24'h00_0300, 12'd2, 16'h0200);
        pulse(); chk("R6 first down", 24'h00_0100);
        pulse(); chk("R6 saturate at zero", 24'h00_0000);
        pulse(); chk("R6 stays at zero", 24'h00_0000);
        pulse(); chk("R6 stays at zero end", 24'h00_0000);
        pulse(); chk("R3 up from zero", 24'h00_0200);
        pulse(); chk("R7 overshoot clamped", 24'h00_0300);
        pulse(); chk("R7 stays at crest", 24'h00_0300);
        pulse(); chk("R5 last up lands on P", 24'h00_0300);
        pulse(); chk("R5 new down ramp", 24'h00_0100);
    endtask

    task automatic t_reenable();
        restart(24'h20_0000, 12'd3, 16'h0100);
        pulse();
        pulse();
        chk("R3 mid ramp", 24'h1F_FE00);
        ss_en = 1'b0;
        #1;
        chk("R1 bypass on disable", 24'h20_0000);
        @(negedge clk);
        ss_en = 1'b1;
        @(negedge clk);
        chk("R2 restart at crest", 24'h20_0000);
        for (int k = 1; k <= 6; k++) pulse();
        chk("R2 full down ramp after restart", 24'h1F_FA00);
        pulse();
        chk("R2 cleared counter turns after 6", 24'h1F_FB00);
    endtask

    task automatic t_zero_period();
        restart(24'h05_4321, 12'd0, 16'h1000);
        for (int i = 0; i < 3; i++) begin
            pulse();
            chk("R8 zero period holds P", 24'h05_4321);
        end
    endtask

    task automatic t_lower_p();
        restart(24'h12_3456, 12'd4, 16'h0400);
        nom_p = 24'h10_0000;
        @(negedge clk);
        chk("R7 pulled to lowered P", 24'h10_0000);
        pulse();
        chk("R3 down from lowered P", 24'h0F_FC00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_triangle();
        t_saturate();
        t_reenable();
        t_zero_period();
        t_lower_p();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule